// File: doc/BRIEF.md
# Three-Channel Reload Down-Counter Timer

This block gives a chip three independent 32-bit down-counters behind a small memory-mapped register port. Each channel has a reload value, a live count and a 16-bit control word. The control word picks what the channel counts: a tap of a free-running divider of the block clock (by 4, 16, 64 or 256), a slow reference input near 16 kHz, or an external clock pin. It also picks which edges of that source count (rising, falling or both), and it holds a sticky underflow flag with its own interrupt enable.

A shared start register runs or freezes each channel. When a running channel that already holds zero gets one more tick, it reloads from its reload value and raises its underflow flag in the same cycle. Software clears the flag by writing 0 to it. Channel 2 also has a read-only capture register. A rising edge on the capture pin copies the channel 2 count into it.

Reads are combinational from the byte address. Writes take effect on the next clock edge. The two slow clock inputs and the capture pin are asynchronous, and each passes through a two-flop synchronizer before its edges are detected.

Top module: `tmr3_top`

## Requirements
- R1: After reset every register reads zero and every interrupt output is low.
- R2: Registers sit at these byte offsets: start 0x02; channel 0 reload/count/control 0x04/0x08/0x0C; channel 1 0x10/0x14/0x18; channel 2 0x1C/0x20/0x24; capture 0x28. Reload and count read back the full 32 bits written. Control reads back bits 5:0 as written, and bits 15:9 and 7:6 read zero.
- R3: Start bits 0, 1 and 2 run channels 0, 1 and 2. A channel whose start bit is clear holds its count, and other channels do not affect it.
- R4: Control bits 2:0 choose the source: 0 = clock/4, 1 = clock/16, 2 = clock/64, 3 = clock/256, 4 = reference input, 5 = external input. Codes 6 and 7 never tick.
- R5: Control bits 4:3 choose the edge: 00 = rising, 01 = falling, 1x = both. A running channel on a divider tap with rising or falling edges decrements once every N block cycles, where N is the ratio. With both edges it decrements once every N/2 cycles.
- R6: On a tick, a count above zero drops by one. A count of zero reloads from the reload register and sets control bit 8 (underflow flag) in the same cycle.
- R7: The flag stays set until a control write with bit 8 = 0. A write with bit 8 = 1 leaves it unchanged. An underflow in the same cycle as a clearing write leaves the flag set.
- R8: Interrupt output i is high exactly when channel i has its flag (bit 8) and its enable (bit 5) both set.
- R9: The reference and external inputs are synchronized through two flops. Each selected edge causes exactly one decrement, and the other edge direction causes none.
- R10: A rising edge on the capture input copies channel 2's count into the capture register. Bus writes to offset 0x28 have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ref_clk_in | input | 1 | Asynchronous slow reference clock (about 16 kHz) |
| ext_clk_in | input | 1 | Asynchronous external count clock |
| cap_in | input | 1 | Asynchronous capture strobe for channel 2 |
| irq_o | output | 3 | Per-channel underflow interrupts |

## Verification
A wrong divider tap or a wrong edge decode shows up in the spacing of count changes seen on the bus. That spacing is wrong from the second tick, within at most 512 cycles. Bad reload or flag state shows at the first underflow as a wrong count after zero, a missing bit 8, or a wrong interrupt level in the same cycle. A lost race between a clearing write and an underflow leaves bit 8 low on the next read. A capture fault shows as a capture value that differs from the frozen channel 2 count a few cycles after the strobe.

// File: rtl/tmr3_pkg.sv
package tmr3_pkg;
    localparam int CNT_W   = 32;
    localparam int NUM_CH  = 3;
    localparam int ADDR_W  = 6;
    localparam int NUM_SRC = 6;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_BTH2 = 2'b11
    } edge_mode_e;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] reload;
        logic [2:0]       src;
        edge_mode_e       edg;
        logic             ie;
        logic             flag;
        logic             prev;
    } chan_state_t;

    function automatic logic [ADDR_W-1:0] chan_base(input int ch);
        return ADDR_W'(4 + 12 * ch);
    endfunction
endpackage

// File: rtl/tmr3_prescale.sv
module tmr3_prescale #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [DIV_W-1:0] div_o
);
    logic [DIV_W-1:0] div_d, div_q;

    always_comb begin
        div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign div_o = div_q;
endmodule

// File: rtl/tmr3_sync.sv
module tmr3_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] s1_d, s1_q, s2_d, s2_q;

    always_comb begin
        s1_d = async_i;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign sync_o = s2_q;
endmodule

// File: rtl/tmr3_chan.sv
module tmr3_chan
    import tmr3_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic [NUM_SRC-1:0] src_lvl_i,
    input  logic               wr_reload_i,
    input  logic               wr_count_i,
    input  logic               wr_ctrl_i,
    input  logic [CNT_W-1:0]   wdata_i,
    output logic [CNT_W-1:0]   reload_o,
    output logic [CNT_W-1:0]   count_o,
    output logic [15:0]        ctrl_o,
    output logic               irq_o
);
    chan_state_t st_d, st_q;
    logic        lvl;
    logic        tick;
    logic        uflow;

    always_comb begin
        st_d = st_q;
        lvl  = (st_q.src < 3'(NUM_SRC)) ? src_lvl_i[st_q.src] : 1'b0;
        unique case (st_q.edg)
            EDGE_RISE: tick = lvl & ~st_q.prev;
            EDGE_FALL: tick = ~lvl & st_q.prev;
            default:   tick = lvl ^ st_q.prev;
        endcase
        uflow      = run_i && tick && (st_q.count == '0);
        st_d.prev  = lvl;

        if (run_i && tick) begin
            st_d.count = uflow ? st_q.reload : st_q.count - 1'b1;
        end
        if (wr_count_i)  st_d.count  = wdata_i;
        if (wr_reload_i) st_d.reload = wdata_i;

        if (wr_ctrl_i) begin
            st_d.src = wdata_i[2:0];
            st_d.edg = edge_mode_e'(wdata_i[4:3]);
            st_d.ie  = wdata_i[5];
            if (!wdata_i[8]) st_d.flag = 1'b0;
        end
        if (uflow) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reload_o = st_q.reload;
    assign count_o  = st_q.count;
    assign ctrl_o   = {7'b0, st_q.flag, 2'b0, st_q.ie, st_q.edg, st_q.src};
    assign irq_o    = st_q.flag & st_q.ie;

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !wr_count_i) |=> $stable(count_o)); // R3
    AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick && count_o != '0 && !wr_count_i) |=> (count_o == $past(count_o) - 1'b1)); // R6
    AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick && count_o == '0 && !wr_count_i) |=> (count_o == $past(reload_o))); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o[8] && !(wr_ctrl_i && !wdata_i[8])) |=> ctrl_o[8]); // R7
endmodule

// File: rtl/tmr3_top.sv
module tmr3_top
    import tmr3_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              ref_clk_in,
    input  logic              ext_clk_in,
    input  logic              cap_in,
    output logic [NUM_CH-1:0] irq_o
);
    localparam int DIV_W = 8;
    localparam logic [ADDR_W-1:0] START_OFS = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] CAP_OFS   = ADDR_W'(40);

    typedef struct packed {
        logic [NUM_CH-1:0] start;
        logic [CNT_W-1:0]  cap;
        logic              cap_prev;
    } top_state_t;

    top_state_t         ts_d, ts_q;
    logic [DIV_W-1:0]   div;
    logic [2:0]         sync_lvl;
    logic [NUM_SRC-1:0] src_lvl;
    logic               cap_edge;

    logic [CNT_W-1:0] rl   [NUM_CH];
    logic [CNT_W-1:0] cnt  [NUM_CH];
    logic [15:0]      ctl  [NUM_CH];
    logic [NUM_CH-1:0] wr_rl, wr_cnt, wr_ctl;

    tmr3_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .div_o (div)
    );

    tmr3_sync #(.W(3)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cap_in, ext_clk_in, ref_clk_in}),
        .sync_o  (sync_lvl)
    );

    assign src_lvl = {sync_lvl[1], sync_lvl[0], div[7], div[5], div[3], div[1]};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign wr_rl[c]  = bus_we && (bus_addr == chan_base(c));
        assign wr_cnt[c] = bus_we && (bus_addr == chan_base(c) + ADDR_W'(4));
        assign wr_ctl[c] = bus_we && (bus_addr == chan_base(c) + ADDR_W'(8));

        tmr3_chan u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .run_i       (ts_q.start[c]),
            .src_lvl_i   (src_lvl),
            .wr_reload_i (wr_rl[c]),
            .wr_count_i  (wr_cnt[c]),
            .wr_ctrl_i   (wr_ctl[c]),
            .wdata_i     (bus_wdata),
            .reload_o    (rl[c]),
            .count_o     (cnt[c]),
            .ctrl_o      (ctl[c]),
            .irq_o       (irq_o[c])
        );
    end

    always_comb begin
        ts_d          = ts_q;
        cap_edge      = sync_lvl[2] & ~ts_q.cap_prev;
        ts_d.cap_prev = sync_lvl[2];
        if (bus_we && bus_addr == START_OFS) ts_d.start = bus_wdata[NUM_CH-1:0];
        if (cap_edge) ts_d.cap = cnt[NUM_CH-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == START_OFS) bus_rdata = CNT_W'(ts_q.start);
        if (bus_addr == CAP_OFS)   bus_rdata = ts_q.cap;
        for (int c = 0; c < NUM_CH; c++) begin
            if (bus_addr == chan_base(c))               bus_rdata = rl[c];
            if (bus_addr == chan_base(c) + ADDR_W'(4))  bus_rdata = cnt[c];
            if (bus_addr == chan_base(c) + ADDR_W'(8))  bus_rdata = CNT_W'(ctl[c]);
        end
    end

    AST_CAP_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_edge |=> $stable(ts_q.cap)); // R10
    AST_CAP_TAKES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        cap_edge |=> (ts_q.cap == $past(cnt[NUM_CH-1]))); // R10
endmodule

// File: tb/tmr3_top_test.sv
module tmr3_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ref_clk_in = 1'b0;
    logic        ext_clk_in = 1'b0;
    logic        cap_in = 1'b0;
    logic [2:0]  irq_o;

    int checks = 0;
    int errors = 0;

    tmr3_top uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ref_clk_in(ref_clk_in),
        .ext_clk_in(ext_clk_in), .cap_in(cap_in), .irq_o(irq_o)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // cycles between two successive count changes of a running channel
    task automatic period(input logic [5:0] cnt_a, output int gap);
        logic [31:0] v, last;
        int t0;
        int n;
        t0 = -1; gap = -1; n = 0;
        rd(cnt_a, last);
        while (gap < 0 && n < 2000) begin
            rd(cnt_a, v);
            n++;
            if (v != last) begin
                if (t0 >= 0) gap = n - t0;
                t0 = n;
                last = v;
            end
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 44; a += 2) begin
            rd(6'(a), v);
            check("R1 reg reset", v, 32'h0);
        end
        check("R1 irq reset", 32'(irq_o), 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        for (int c = 0; c < 3; c++) begin
            wr(6'(4 + 12*c), 32'hA5A5_0000 + c);
            wr(6'(8 + 12*c), 32'h1234_5670 + c);
            wr(6'(12 + 12*c), 32'hFFFF_FEFF);
        end
        for (int c = 0; c < 3; c++) begin
            rd(6'(4 + 12*c), v);  check("R2 reload readback", v, 32'hA5A5_0000 + c);
            rd(6'(8 + 12*c), v);  check("R2 count readback", v, 32'h1234_5670 + c);
            rd(6'(12 + 12*c), v); check("R2 control mask", v, 32'h0000_003F);
            wr(6'(12 + 12*c), 32'h0);
        end
        wr(6'h02, 32'h5);
        rd(6'h02, v); check("R2 start readback", v, 32'h5);
        wr(6'h02, 32'h0);
    endtask

    task automatic t_hold();
        logic [31:0] v;
        wr(6'h08, 32'd500); wr(6'h14, 32'd500); wr(6'h20, 32'd500);
        wr(6'h0C, 32'h10); wr(6'h18, 32'h10); wr(6'h24, 32'h10);
        wr(6'h02, 32'h2);
        repeat (40) @(negedge clk);
        wr(6'h02, 32'h0);
        rd(6'h08, v); check("R3 ch0 held", v, 32'd500);
        rd(6'h20, v); check("R3 ch2 held", v, 32'd500);
        rd(6'h14, v); checks++;
        if (v >= 32'd500) begin errors++; $display("FAIL R3 ch1 ran actual=%0d expected<500", v); end
        rd(6'h14, v);
        repeat (30) @(negedge clk);
        begin logic [31:0] w; rd(6'h14, w); check("R3 ch1 holds after stop", w, v); end
    endtask

    task automatic t_div();
        int g;
        int exp_gap [4] = '{4, 16, 64, 256};
        wr(6'h04, 32'd100000); wr(6'h08, 32'd100000);
        wr(6'h02, 32'h1);
        for (int s = 0; s < 4; s++) begin
            wr(6'h0C, 32'(s));
            period(6'h08, g);
            check("R4 rising tap gap", 32'(g), 32'(exp_gap[s]));
        end
        wr(6'h0C, 32'h10); period(6'h08, g);
        check("R5 both edges /4", 32'(g), 32'd2);
        wr(6'h0C, 32'h09); period(6'h08, g);
        check("R5 falling /16", 32'(g), 32'd16);
        wr(6'h0C, 32'h06);
        begin
            logic [31:0] a, b;
            rd(6'h08, a); repeat (600) @(negedge clk); rd(6'h08, b);
            check("R4 code 6 no tick", b, a);
        end
        wr(6'h02, 32'h0);
    endtask

    task automatic t_underflow();
        logic [31:0] v, last;
        logic [31:0] seq [4];
        int k;
        wr(6'h04, 32'd3); wr(6'h08, 32'd2); wr(6'h0C, 32'h10);
        wr(6'h02, 32'h1);
        k = 0;
        rd(6'h08, last);
        for (int i = 0; i < 30 && k < 4; i++) begin
            rd(6'h08, v);
            if (v != last) begin seq[k] = v; k++; last = v; end
        end
        wr(6'h02, 32'h0);
        check("R6 step 2->1", seq[0], 32'd1);
        check("R6 step 1->0", seq[1], 32'd0);
        check("R6 reload at zero", seq[2], 32'd3);
        check("R6 after reload", seq[3], 32'd2);
        rd(6'h0C, v); check("R6 flag set", v, 32'h110);
        check("R8 irq off when disabled", 32'(irq_o), 32'h0);
        wr(6'h0C, 32'h130);
        rd(6'h0C, v); check("R7 write 1 keeps flag", v, 32'h130);
        check("R8 irq on", 32'(irq_o), 32'h1);
        wr(6'h0C, 32'h030);
        rd(6'h0C, v); check("R7 write 0 clears", v, 32'h030);
        check("R8 irq off after clear", 32'(irq_o), 32'h0);
    endtask

    task automatic t_race();
        logic [31:0] v;
        int n;
        wr(6'h10, 32'd5); wr(6'h14, 32'd2); wr(6'h18, 32'h20);
        wr(6'h02, 32'h2);
        n = 0;
        v = 32'hFFFF_FFFF;
        while (v != 32'd0 && n < 100) begin rd(6'h14, v); n++; end
        repeat (2) @(negedge clk);
        wr(6'h18, 32'h20);
        wr(6'h02, 32'h0);
        rd(6'h18, v); check("R7 underflow beats clear", v, 32'h120);
        check("R8 irq ch1", 32'(irq_o), 32'h2);
        wr(6'h18, 32'h0);
    endtask

    task automatic t_slow_inputs();
        logic [31:0] v;
        wr(6'h08, 32'd50); wr(6'h0C, 32'h0D); wr(6'h02, 32'h1);
        ext_clk_in = 1'b1; repeat (6) @(negedge clk);
        rd(6'h08, v); check("R9 ext rising ignored in falling mode", v, 32'd50);
        ext_clk_in = 1'b0; repeat (6) @(negedge clk);
        rd(6'h08, v); check("R9 ext falling counts once", v, 32'd49);
        wr(6'h0C, 32'h14);
        ref_clk_in = 1'b1; repeat (8) @(negedge clk);
        ref_clk_in = 1'b0; repeat (8) @(negedge clk);
        rd(6'h08, v); check("R9 ref both edges", v, 32'd47);
        wr(6'h02, 32'h0);
    endtask

    task automatic t_capture();
        logic [31:0] v;
        wr(6'h20, 32'h0000_1234);
        cap_in = 1'b1; repeat (5) @(negedge clk); cap_in = 1'b0;
        repeat (3) @(negedge clk);
        rd(6'h28, v); check("R10 captured count", v, 32'h1234);
        wr(6'h28, 32'hDEAD_BEEF);
        wr(6'h20, 32'h55);
        repeat (4) @(negedge clk);
        rd(6'h28, v); check("R10 bus write ignored", v, 32'h1234);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_hold();
        t_div();
        t_underflow();
        t_race();
        t_slow_inputs();
        t_capture();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule